// File: doc/BRIEF.md
# Display Identification Block Fetch Sequencer

This block pulls the 128-byte display identification block from an attached monitor through a transaction engine that speaks the DDC bus. The engine handles the bit-level bus work, which is outside this block. The sequencer cuts the read into short bursts. Before each burst it pulses a receive-FIFO clear, then presents a segment number, a word offset and a byte count, and pulses a start strobe. It collects the returned bytes into a local buffer while keeping a running byte sum.

After the last burst the sequencer judges the data in three steps, in this order:
- the checksum;
- the version rules;
- the four detailed timing descriptors.

It then reports the lowest-numbered usable descriptor or an error code. A burst that never completes, or a block whose sum is wrong, causes the whole block to be read again from offset zero. The number of extra attempts is bounded. The engine-enable output is released when the sequence ends, whatever the result. The stored bytes stay readable through a combinational read port for whatever decodes the timing.

Top module: `edid_fetch_seq`

## Requirements
- R1: A fetch reads exactly BLOCK_BYTES (128) bytes starting at offset 0. Each returned byte is stored at its block offset, and `rdData` shows the stored byte at `rdAddr` combinationally.
- R2: Each burst requests min(BURST_MAX, bytes remaining) bytes. The offset then advances by that length, so the last burst carries the remainder.
- R3: Each request drives `xferSeg` = offset >> 8 and `xferOfs` = offset[7:0].
- R4: `fifoClear` is high for exactly the one cycle immediately before each `xferStart` cycle.
- R5: If `xferDone` does not arrive within TIMEOUT_CYCLES cycles after a request, the attempt fails with a timeout.
- R6: A failed attempt (timeout or bad checksum) restarts the full read at offset 0, up to MAX_RETRIES (2) times. After that, the fetch ends with the code of the last failure.
- R7: The checksum passes when the sum of all 128 bytes modulo 256 is zero. Otherwise the failure code is 2.
- R8: When the checksum passes, the data is accepted only if byte 18 equals 1 and either byte 19 is at least 3 or bit 1 of byte 24 is set. Otherwise the fetch ends with code 3.
- R9: Descriptor i (i = 0..3) starts at byte 54 + 18*i and is usable when either of its first two bytes is nonzero. `timingIdx` reports the lowest usable i. If none is usable, the code is 4.
- R10: `errCode` uses 0 none, 1 timeout, 2 checksum, 3 version, 4 no timing.
  - `done` is a one-cycle pulse that carries the final code.
  - `busy` and `engineEnable` are high from the cycle after an accepted start until the `done` cycle, in which both are low.
- R11: A `start` pulse while `busy` is high has no effect: no second fetch and no extra requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch (ignored while busy) |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 3 | Result code, held until the next start |
| timingIdx | output | 2 | Index of the first usable descriptor |
| engineEnable | output | 1 | Enables the transaction engine while fetching |
| fifoClear | output | 1 | Receive FIFO clear pulse |
| xferStart | output | 1 | Burst request strobe |
| xferSeg | output | 8 | Segment number of the burst |
| xferOfs | output | 8 | Word offset of the burst |
| xferCount | output | CNT_W | Byte count of the burst |
| xferDone | input | 1 | Burst completion pulse from the engine |
| rxValid | input | 1 | Returned byte strobe |
| rxData | input | 8 | Returned byte |
| rdAddr | input | IDX_W | Buffer read address |
| rdData | output | 8 | Buffer read data |

## Verification
The assertions assume the engine returns exactly the requested number of bytes and only then pulses `xferDone`. They also assume the engine sends no byte strobes outside a burst and, when it stays silent, stays silent until the sequencer gives up. The bench engine model is built around those assumptions. It streams one byte every other cycle and then gives a single completion pulse. Failures are injected only on whole attempts: either a missing answer to the first burst of an attempt, or a corrupted byte 5. A small burst limit of 12 makes the final burst a short one.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_TIMEOUT   = 3'd1,
    ERR_CHECKSUM  = 3'd2,
    ERR_VERSION   = 3'd3,
    ERR_NO_TIMING = 3'd4
  } fetchErr_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic beginAttempt;  // offset and sum back to zero
    logic latchBurst;    // new burst issued, clear byte counter
    logic acceptRx;      // returned bytes may be stored
    logic advance;       // burst finished, move offset on
  } dpStrobe_t;

  // byte positions decoded by the acceptance logic
  localparam int VER_BYTE      = 18;
  localparam int REV_BYTE      = 19;
  localparam int FEAT_BYTE     = 24;
  localparam int FEAT_PREF_BIT = 1;
  localparam int MIN_REV       = 3;
  localparam int DTD_BASE      = 54;
  localparam int DTD_STRIDE    = 18;
  localparam int DTD_COUNT     = 4;
  localparam int OFS_W         = 16;

endpackage

// File: rtl/edid_fetch_dp.sv
module edid_fetch_dp
  import edid_fetch_pkg::*;
#(
  parameter int BLOCK_BYTES = 128,
  parameter int BURST_MAX   = 16,
  localparam int IDX_W = $clog2(BLOCK_BYTES),
  localparam int CNT_W = $clog2(BURST_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 rxValid,
  input  logic [7:0]           rxData,
  input  logic [IDX_W-1:0]     rdAddr,
  output logic [7:0]           rdData,
  output logic [7:0]           xferSeg,
  output logic [7:0]           xferOfs,
  output logic [CNT_W-1:0]     xferCount,
  output logic                 lastBurst,
  output logic                 sumOk,
  output logic                 versionOk,
  output logic [DTD_COUNT-1:0] dtdUsable
);

  localparam logic [OFS_W-1:0] BLOCK_W = OFS_W'(BLOCK_BYTES);
  localparam logic [OFS_W-1:0] BURST_W = OFS_W'(BURST_MAX);

  logic [OFS_W-1:0] offset;
  logic [OFS_W-1:0] rxCnt;
  logic [OFS_W-1:0] remaining;
  logic [OFS_W-1:0] burstLen;
  logic [OFS_W-1:0] wrPos;
  logic [7:0]       sum;
  logic [7:0]       mem [BLOCK_BYTES];

  always_comb begin
    remaining = BLOCK_W - offset;
    burstLen  = (remaining > BURST_W) ? BURST_W : remaining;
    wrPos     = offset + rxCnt;
  end

  assign xferSeg   = offset[15:8];
  assign xferOfs   = offset[7:0];
  assign xferCount = burstLen[CNT_W-1:0];
  assign lastBurst = (offset + burstLen) >= BLOCK_W;
  assign sumOk     = (sum == 8'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset <= '0;
      rxCnt  <= '0;
      sum    <= '0;
    end else begin
      if (strobe.beginAttempt) begin
        offset <= '0;
        sum    <= '0;
      end else if (strobe.advance) begin
        offset <= offset + burstLen;
      end
      if (strobe.latchBurst) begin
        rxCnt <= '0;
      end else if (strobe.acceptRx && rxValid) begin
        rxCnt <= rxCnt + 1'b1;
        sum   <= sum + rxData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.acceptRx && rxValid && (wrPos < BLOCK_W))
      mem[wrPos[IDX_W-1:0]] <= rxData;
  end

  assign rdData    = mem[rdAddr];
  assign versionOk = (mem[VER_BYTE] == 8'd1) &&
                     ((mem[REV_BYTE] >= 8'(MIN_REV)) || mem[FEAT_BYTE][FEAT_PREF_BIT]);

  for (genvar g = 0; g < DTD_COUNT; g++) begin : gDtd
    assign dtdUsable[g] = (mem[DTD_BASE + g*DTD_STRIDE] != 8'd0) ||
                          (mem[DTD_BASE + g*DTD_STRIDE + 1] != 8'd0);
  end

  assert_offset_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    offset <= BLOCK_W);

  assert_burst_size_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchBurst) |-> (burstLen != '0) && (burstLen <= BURST_W));

  // engine assumption: a burst delivers exactly the requested count
  assert_burst_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (rxCnt == burstLen));

endmodule

// File: rtl/edid_fetch_ctl.sv
module edid_fetch_ctl
  import edid_fetch_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 40_000_000,
  parameter int MAX_RETRIES    = 2,
  localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1),
  localparam int RTY_W = $clog2(MAX_RETRIES + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 xferDone,
  input  logic                 lastBurst,
  input  logic                 sumOk,
  input  logic                 versionOk,
  input  logic [DTD_COUNT-1:0] dtdUsable,
  output dpStrobe_t            strobe,
  output logic                 xferStart,
  output logic                 fifoClear,
  output logic                 engineEnable,
  output logic                 busy,
  output logic                 done,
  output fetchErr_t            errCode,
  output logic [1:0]           timingIdx
);

  typedef enum logic [2:0] {S_IDLE, S_CLEAR, S_ISSUE, S_WAIT, S_CHECK} state_t;

  localparam logic [TMO_W-1:0] TMO_LAST  = TMO_W'(TIMEOUT_CYCLES - 1);
  localparam logic [RTY_W-1:0] RTY_LIMIT = RTY_W'(MAX_RETRIES);

  state_t           state;
  logic [TMO_W-1:0] timer;
  logic [RTY_W-1:0] tries;

  logic      timedOut, badSum, failNow, retryOk, checkDone, finishNow;
  fetchErr_t failCode, checkCode, finishCode;
  logic [1:0] firstIdx;

  always_comb begin
    firstIdx = '0;
    for (int i = DTD_COUNT - 1; i >= 0; i--)
      if (dtdUsable[i]) firstIdx = 2'(i);
  end

  always_comb begin
    timedOut   = (state == S_WAIT) && !xferDone && (timer == TMO_LAST);
    badSum     = (state == S_CHECK) && !sumOk;
    failNow    = timedOut || badSum;
    failCode   = timedOut ? ERR_TIMEOUT : ERR_CHECKSUM;
    retryOk    = tries < RTY_LIMIT;
    checkDone  = (state == S_CHECK) && sumOk;
    checkCode  = !versionOk ? ERR_VERSION :
                 (dtdUsable == '0) ? ERR_NO_TIMING : ERR_NONE;
    finishNow  = (failNow && !retryOk) || checkDone;
    finishCode = failNow ? failCode : checkCode;

    strobe.beginAttempt = ((state == S_IDLE) && start) || (failNow && retryOk);
    strobe.latchBurst   = (state == S_ISSUE);
    strobe.acceptRx     = (state == S_WAIT);
    strobe.advance      = (state == S_WAIT) && xferDone;
  end

  assign busy         = (state != S_IDLE);
  assign engineEnable = busy;
  assign xferStart    = (state == S_ISSUE);
  assign fifoClear    = (state == S_CLEAR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      timer     <= '0;
      tries     <= '0;
      done      <= 1'b0;
      errCode   <= ERR_NONE;
      timingIdx <= '0;
    end else begin
      done <= 1'b0;
      if (finishNow) begin
        state     <= S_IDLE;
        done      <= 1'b1;
        errCode   <= finishCode;
        timingIdx <= (finishCode == ERR_NONE) ? firstIdx : 2'd0;
      end else if (failNow) begin
        tries <= tries + 1'b1;
        state <= S_CLEAR;
      end else begin
        unique case (state)
          S_IDLE: if (start) begin
            state   <= S_CLEAR;
            tries   <= '0;
            errCode <= ERR_NONE;
          end
          S_CLEAR: state <= S_ISSUE;
          S_ISSUE: begin
            timer <= '0;
            state <= S_WAIT;
          end
          S_WAIT: begin
            if (xferDone) state <= lastBurst ? S_CHECK : S_CLEAR;
            else          timer <= timer + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_clear_before_issue_R4: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> $past(fifoClear));

  assert_wait_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> (timer < TMO_W'(TIMEOUT_CYCLES)));

  assert_retry_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    tries <= RTY_LIMIT);

  assert_accept_rule_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && (errCode == ERR_NONE)) |-> versionOk && (dtdUsable != '0));

  assert_release_engine_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!engineEnable && $past(busy)));

endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
  import edid_fetch_pkg::*;
#(
  parameter int BLOCK_BYTES    = 128,
  parameter int BURST_MAX      = 16,
  parameter int TIMEOUT_CYCLES = 40_000_000,
  parameter int MAX_RETRIES    = 2,
  localparam int IDX_W = $clog2(BLOCK_BYTES),
  localparam int CNT_W = $clog2(BURST_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [2:0]       errCode,
  output logic [1:0]       timingIdx,
  output logic             engineEnable,
  output logic             fifoClear,
  output logic             xferStart,
  output logic [7:0]       xferSeg,
  output logic [7:0]       xferOfs,
  output logic [CNT_W-1:0] xferCount,
  input  logic             xferDone,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [7:0]       rdData
);

  dpStrobe_t            strobe;
  fetchErr_t            errState;
  logic                 lastBurst, sumOk, versionOk;
  logic [DTD_COUNT-1:0] dtdUsable;

  edid_fetch_ctl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .MAX_RETRIES   (MAX_RETRIES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .xferDone(xferDone),
    .lastBurst(lastBurst), .sumOk(sumOk), .versionOk(versionOk),
    .dtdUsable(dtdUsable), .strobe(strobe), .xferStart(xferStart),
    .fifoClear(fifoClear), .engineEnable(engineEnable), .busy(busy),
    .done(done), .errCode(errState), .timingIdx(timingIdx)
  );

  edid_fetch_dp #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .BURST_MAX  (BURST_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxValid(rxValid),
    .rxData(rxData), .rdAddr(rdAddr), .rdData(rdData),
    .xferSeg(xferSeg), .xferOfs(xferOfs), .xferCount(xferCount),
    .lastBurst(lastBurst), .sumOk(sumOk), .versionOk(versionOk),
    .dtdUsable(dtdUsable)
  );

  assign errCode = errState;

endmodule

// File: tb/edid_fetch_seq_bench.sv
`timescale 1ns/1ps
module edid_fetch_seq_bench;

  localparam int BM    = 12;
  localparam int TMO   = 300;
  localparam int NBYTE = 128;
  localparam int NB    = (NBYTE + BM - 1) / BM;
  localparam int CW    = $clog2(BM + 1);

  logic clk = 0, rstN = 0, start = 0;
  logic busy, done, engineEnable, fifoClear, xferStart;
  logic [2:0] errCode;
  logic [1:0] timingIdx;
  logic [7:0] xferSeg, xferOfs, rxData, rdData;
  logic [CW-1:0] xferCount;
  logic xferDone, rxValid;
  logic [6:0] rdAddr = '0;

  always #2.5 clk = ~clk;

  edid_fetch_seq #(.BLOCK_BYTES(NBYTE), .BURST_MAX(BM), .TIMEOUT_CYCLES(TMO), .MAX_RETRIES(2))
  u_edid_fetch_seq (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .errCode(errCode), .timingIdx(timingIdx), .engineEnable(engineEnable),
    .fifoClear(fifoClear), .xferStart(xferStart), .xferSeg(xferSeg),
    .xferOfs(xferOfs), .xferCount(xferCount), .xferDone(xferDone),
    .rxValid(rxValid), .rxData(rxData), .rdAddr(rdAddr), .rdData(rdData)
  );

  int nChecks = 0, nFail = 0;
  int startCount = 0, silentLeft = 0, corruptLeft = 0, expOfs = 0;
  bit corruptNow = 0, lastClear = 0;
  logic [7:0] img [NBYTE];

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic buildImage(int ver, int rev, bit pref, logic [3:0] mask);
    logic [7:0] s;
    for (int i = 0; i < NBYTE; i++) img[i] = 8'(i * 37 + 11);
    img[18] = 8'(ver);
    img[19] = 8'(rev);
    img[24] = pref ? 8'h02 : 8'h00;
    for (int d = 0; d < 4; d++) begin
      img[54 + 18*d]     = mask[d] ? 8'(d + 1) : 8'h00;
      img[54 + 18*d + 1] = 8'h00;
    end
    s = 8'h00;
    for (int i = 0; i < NBYTE - 1; i++) s = s + img[i];
    img[NBYTE-1] = 8'h00 - s;
  endtask

  // R4 monitor: clear must sit in the cycle before every request
  always @(negedge clk) begin
    if (xferStart) check(lastClear, "R4", "clear before request", int'(lastClear), 1);
    lastClear = fifoClear;
  end

  // engine model
  initial begin
    int o, c;
    bit silent;
    rxValid = 0; xferDone = 0; rxData = 0;
    forever begin
      @(negedge clk);
      if (xferStart) begin
        o = int'(xferOfs) + 256 * int'(xferSeg);
        c = int'(xferCount);
        startCount++;
        check(o == expOfs || o == 0, "R2", "burst offset", o, expOfs);
        check(c == ((NBYTE - o) < BM ? NBYTE - o : BM), "R2", "burst count", c,
              (NBYTE - o) < BM ? NBYTE - o : BM);
        check(int'(xferSeg) == (o >> 8) && int'(xferOfs) == (o & 255), "R3", "segment/offset",
              int'(xferSeg), o >> 8);
        silent = 0;
        if (o == 0) begin
          corruptNow = 0;
          if (silentLeft > 0) begin silentLeft--; silent = 1; end
          else if (corruptLeft > 0) begin corruptLeft--; corruptNow = 1; end
        end
        if (silent) expOfs = 0;
        else begin
          for (int i = 0; i < c; i++) begin
            @(negedge clk);
            rxValid = 1;
            rxData  = img[o+i] ^ ((corruptNow && (o + i) == 5) ? 8'h01 : 8'h00);
            @(negedge clk);
            rxValid = 0;
          end
          @(negedge clk); xferDone = 1;
          @(negedge clk); xferDone = 0;
          expOfs = (o + c >= NBYTE) ? 0 : o + c;
        end
      end
    end
  end

  task automatic waitDone(string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done, req, "done seen", int'(done), 1);
  endtask

  task automatic runFetch(int expErr, int expIdx, int expStarts, string req);
    startCount = 0; expOfs = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(busy && engineEnable, "R10", "busy after start", int'(busy), 1);
    waitDone(req);
    check(int'(errCode) == expErr, req, "error code", int'(errCode), expErr);
    if (expErr == 0) check(int'(timingIdx) == expIdx, "R9", "timing index", int'(timingIdx), expIdx);
    check(startCount == expStarts, req, "request count", startCount, expStarts);
    check(!busy && !engineEnable, "R10", "engine released at done", int'(engineEnable), 0);
    @(negedge clk);
    check(!done, "R10", "done single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", "run expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int fi;
    buildImage(1, 3, 0, 4'b0001);
    repeat (4) @(negedge clk);
    check(!busy && !done && !engineEnable && !xferStart && !fifoClear, "R10", "reset state", int'(busy), 0);
    rstN = 1;
    @(negedge clk);
    check(!busy && !engineEnable, "R10", "idle after reset", int'(busy), 0);

    // R9: every usable-descriptor mask
    for (int m = 0; m < 16; m++) begin
      buildImage(1, 3, 0, 4'(m));
      fi = (m & 1) ? 0 : (m & 2) ? 1 : (m & 4) ? 2 : 3;
      runFetch(m == 0 ? 4 : 0, fi, NB, "R9");
    end

    // R1: stored bytes through the read port
    for (int a = 0; a < NBYTE; a++) begin
      @(negedge clk); rdAddr = 7'(a); #1;
      check(rdData == img[a], "R1", "stored byte", int'(rdData), int'(img[a]));
    end

    // R8: version and preferred-timing sweep
    for (int v = 0; v < 3; v++)
      for (int r = 0; r < 5; r++)
        for (int p = 0; p < 2; p++) begin
          buildImage(v, r, p[0], 4'b0010);
          runFetch((v == 1 && (r >= 3 || p == 1)) ? 0 : 3, 1, NB, "R8");
        end

    // R7/R6: checksum failures with retries
    buildImage(1, 4, 0, 4'b0100);
    for (int k = 1; k <= 3; k++) begin
      corruptLeft = k; silentLeft = 0;
      runFetch(k <= 2 ? 0 : 2, 2, NB * (k <= 2 ? k + 1 : 3), k <= 2 ? "R6" : "R7");
    end
    corruptLeft = 0;

    // R5/R6: silent engine
    for (int k = 1; k <= 3; k++) begin
      silentLeft = k; corruptLeft = 0;
      runFetch(k <= 2 ? 0 : 1, 2, k <= 2 ? k + NB : 3, "R5");
    end
    silentLeft = 0;

    // R11: start while busy is ignored
    buildImage(1, 3, 1, 4'b1000);
    startCount = 0; expOfs = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    waitDone("R11");
    check(int'(errCode) == 0 && int'(timingIdx) == 3, "R11", "result", int'(timingIdx), 3);
    repeat (60) @(negedge clk);
    check(!busy && startCount == NB, "R11", "no second fetch", startCount, NB);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule